// File: doc/BRIEF.md
# SPI Serial SRAM Word Controller

This block lets a processor bus move single 32-bit words to and from an external serial SRAM attached over a four-wire SPI link. Software sees a small register bank. It sets a serial clock divider, loads a target address and, for stores, a data word. It then writes a command code that either prepares the memory, stores the word, or fetches a word back into the data register.

The prepare command puts the memory into sequential mode. After that, each word moves as one framed transfer: an instruction byte, a 16-bit byte address, then four data bytes, with the most significant byte at the lowest address. The controller drives chip select low for the whole frame and toggles the serial clock at a programmable rate. It presents output bits while the clock is low and captures input bits on each rising clock edge. It never checks whether a device is present, so a missing memory reads back as whatever level the input pin holds.

Software polls a ready flag to know when a command has finished. A separate sticky flag reports that preparation has been done at least once.

Top module: `sram_spi_ctrl`

## Requirements
- R1: Registers sit at bus word offsets 0x08 (command, reads 0), 0x09 (status), 0x0A (divider, 8 bits, reset value 0x02, read back zero-extended), 0x10 (address, 32 bits) and 0x20 (data, 32 bits). The divider, address and data registers read back what was written.
- R2: Writing exactly 0x4 to the command register starts preparation, 0x2 starts a word store and 0x1 starts a word fetch. Any other value starts no transfer.
- R3: Status bit 0 is 0 while a command runs and 1 otherwise, including after reset. Status bit 1 is 0 after reset and becomes 1 when a preparation finishes. No later command clears it. The other status bits read 0.
- R4: The preparation frame is exactly 16 serial bits: byte 0x01 followed by byte 0x40.
- R5: The store frame is exactly 56 serial bits: byte 0x02, the low 16 bits of the address register, then the data register sent most significant bit first.
- R6: The fetch frame is exactly 56 serial bits: byte 0x03, then the low 16 address bits. After these the controller clocks in 32 bits, most significant first, and they replace the data register when the command finishes. A stored word then reads back unchanged from the same address.
- R7: The interface uses SPI mode 0. The serial clock idles low and is high only while chip select is low, and chip select stays low for the whole frame. The output bit never changes on a rising serial clock edge.
- R8: Every serial clock half-period, and the delay from chip select falling to the first rising clock edge, lasts exactly max(divider, 1) system clock cycles.
- R9: A command written while a command is running is ignored. It starts no frame and leaves the data register untouched.
- R10: Between two frames, chip select stays high for at least max(divider, 1) system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write access, 0 for read |
| bus_addr | input | 8 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr (combinational) |
| spi_cs_n | output | 1 | Active-low chip select to the memory |
| spi_sck | output | 1 | Serial clock to the memory |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
Two situations are hard to reach from the ports. The first is a fetch that returns real data, because this needs a device that answers on the input pin in step with the generated clock. The bench therefore contains a behavioural sequential-mode memory that decodes each frame and drives the input bit on falling clock edges. The second is a command arriving mid-frame. For that, the bench slows the divider so a store frame takes hundreds of cycles, then writes fetch and preparation codes while ready is low, and checks that only one frame appears and that the data register survives.

// File: rtl/sram_spi_pkg.sv
// Package: shared register offsets, command codes and operation type
// for the SPI serial SRAM word controller.
package sram_spi_pkg;
    localparam logic [7:0]  OFS_CTRL = 8'h08;
    localparam logic [7:0]  OFS_STAT = 8'h09;
    localparam logic [7:0]  OFS_DIV  = 8'h0A;
    localparam logic [7:0]  OFS_ADDR = 8'h10;
    localparam logic [7:0]  OFS_DATA = 8'h20;

    localparam logic [31:0] CMD_PREP  = 32'h4;
    localparam logic [31:0] CMD_STORE = 32'h2;
    localparam logic [31:0] CMD_FETCH = 32'h1;

    localparam logic [7:0]  INS_MODE  = 8'h01;
    localparam logic [7:0]  MODE_SEQ  = 8'h40;
    localparam logic [7:0]  INS_WRITE = 8'h02;
    localparam logic [7:0]  INS_READ  = 8'h03;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PREP  = 2'd1,
        OP_STORE = 2'd2,
        OP_FETCH = 2'd3
    } op_e;
endpackage

// File: rtl/sram_spi_clkdiv.sv
// Module: half-period tick generator.
// Emits one-cycle tick pulses spaced max(div,1) cycles apart while run is
// high; the count restarts from zero whenever run is low.
// Assumes div is stable while run is high.
module sram_spi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt_q;

    // Purpose: map a zero divider to one.
    always_comb div_eff = (div == '0) ? DIV_W'(1) : div;

    assign tick = run && (cnt_q == div_eff - DIV_W'(1));

    // Purpose: count system cycles within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + DIV_W'(1);
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div_eff)); // R8
endmodule

// File: rtl/sram_spi_engine.sv
// Module: SPI mode-0 frame engine.
// Builds a preparation, store or fetch frame on start, shifts it out MSB
// first, samples the input on rising serial clock edges, then holds
// chip select high for one half-period before reporting done.
// Assumes start only arrives while busy is low.
module sram_spi_engine
    import sram_spi_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int ADDR_BITS = 16,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               start_op,
    input  logic [DIV_W-1:0]  div,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output op_e               done_op,
    output logic [DATA_W-1:0] rx_word,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    localparam int FRAME_W = 8 + ADDR_BITS + DATA_W;
    localparam int PREP_W  = 16;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL, ST_REST} st_e;

    st_e                st_q;
    op_e                op_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   left_q;
    logic [DATA_W-1:0]  rx_q;
    logic               tick;

    sram_spi_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q != ST_IDLE),
        .div  (div),
        .tick (tick)
    );

    // Purpose: assemble the outgoing frame for the requested operation.
    always_comb begin
        case (start_op)
            OP_PREP:  frame = {INS_MODE, MODE_SEQ, {(FRAME_W-16){1'b0}}};
            OP_STORE: frame = {INS_WRITE, addr, wdata};
            default:  frame = {INS_READ, addr, {DATA_W{1'b0}}};
        endcase
    end

    // Purpose: sequence chip select, serial clock and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_NONE;
            sh_q   <= '0;
            left_q <= '0;
            rx_q   <= '0;
            cs_n   <= 1'b1;
            sck    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    sh_q   <= frame;
                    left_q <= (start_op == OP_PREP) ? CNT_W'(PREP_W) : CNT_W'(FRAME_W);
                    op_q   <= start_op;
                    cs_n   <= 1'b0;
                    st_q   <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!sck) begin
                        sck  <= 1'b1;
                        rx_q <= {rx_q[DATA_W-2:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (left_q == CNT_W'(1)) st_q <= ST_TAIL;
                        else begin
                            sh_q   <= sh_q << 1;
                            left_q <= left_q - CNT_W'(1);
                        end
                    end
                end
                ST_TAIL: if (tick) begin
                    cs_n <= 1'b1;
                    st_q <= ST_REST;
                end
                default: if (tick) st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = (st_q == ST_REST) && tick;
    assign done_op = op_q;
    assign rx_word = rx_q;
    assign mosi    = cs_n ? 1'b0 : sh_q[FRAME_W-1];

    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n); // R7
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (cs_n && !sck)); // R7
    AST_GAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REST) |-> cs_n); // R10
endmodule

// File: rtl/sram_spi_regs.sv
// Module: software register bank and command decoder.
// Holds divider, address and data registers, the sticky preparation
// flag, and turns a command write into a start pulse when idle.
// Assumes done is a single-cycle pulse from the engine.
module sram_spi_regs
    import sram_spi_pkg::*;
#(
    parameter int              DIV_W     = 8,
    parameter int              ADDR_BITS = 16,
    parameter int              DATA_W    = 32,
    parameter logic [DIV_W-1:0] DIV_RESET = 8'h02
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 busy,
    input  logic                 done,
    input  op_e                  done_op,
    input  logic [DATA_W-1:0]    rx_word,
    output logic                 start,
    output op_e                  start_op,
    output logic [DIV_W-1:0]     div,
    output logic [ADDR_BITS-1:0] addr,
    output logic [DATA_W-1:0]    wdata
);
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              prep_q;
    logic              wr;

    assign wr = bus_sel && bus_we;

    // Purpose: decode a command write into a start request.
    always_comb begin
        case (bus_wdata)
            CMD_PREP:  start_op = OP_PREP;
            CMD_STORE: start_op = OP_STORE;
            CMD_FETCH: start_op = OP_FETCH;
            default:   start_op = OP_NONE;
        endcase
        start = wr && (bus_addr == OFS_CTRL) && (start_op != OP_NONE) && !busy;
    end

    // Purpose: update registers from the bus and from finished commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_RESET;
            addr_q <= '0;
            data_q <= '0;
            prep_q <= 1'b0;
        end else begin
            if (wr && bus_addr == OFS_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr && bus_addr == OFS_ADDR) addr_q <= bus_wdata;
            if (done && done_op == OP_FETCH)     data_q <= rx_word;
            else if (wr && bus_addr == OFS_DATA) data_q <= bus_wdata;
            if (done && done_op == OP_PREP)      prep_q <= 1'b1;
        end
    end

    // Purpose: return the register selected by the bus offset.
    always_comb begin
        case (bus_addr)
            OFS_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, prep_q, !busy};
            OFS_DIV:  bus_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
            OFS_ADDR: bus_rdata = addr_q;
            OFS_DATA: bus_rdata = data_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign div   = div_q;
    assign addr  = addr_q[ADDR_BITS-1:0];
    assign wdata = data_q;

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R9
    AST_PREP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(prep_q)); // R3
endmodule

// File: rtl/sram_spi_ctrl.sv
// Module: top of the SPI serial SRAM word controller.
// Connects the register bank to the frame engine.
// Assumes a single memory device on the SPI link.
module sram_spi_ctrl
    import sram_spi_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int ADDR_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int DATA_W = 32;

    logic                 start, busy, done;
    op_e                  start_op, done_op;
    logic [DIV_W-1:0]     div;
    logic [ADDR_BITS-1:0] addr;
    logic [DATA_W-1:0]    wdata, rx_word;

    sram_spi_regs #(.DIV_W(DIV_W), .ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W),
                    .DIV_RESET(DIV_W'(2))) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .done_op(done_op), .rx_word(rx_word),
        .start(start), .start_op(start_op), .div(div), .addr(addr), .wdata(wdata)
    );

    sram_spi_engine #(.DIV_W(DIV_W), .ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .div(div), .addr(addr), .wdata(wdata), .busy(busy), .done(done),
        .done_op(done_op), .rx_word(rx_word), .cs_n(spi_cs_n), .sck(spi_sck),
        .mosi(spi_mosi), .miso(spi_miso)
    );
endmodule

// File: tb/sram_spi_ctrl_tb.sv
// Bench: drives the register bank, models a sequential-mode serial SRAM
// on the SPI pins and checks framing, timing and data round trips.
module sram_spi_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, failures = 0;
    int frames = 0, last_bits = 0, bitc = 0;
    logic [63:0] cap = '0, last_cap = '0;
    logic [7:0]  ins_l = 8'h0;
    logic [15:0] adr_l = 16'h0;
    logic [7:0]  mem [0:255];
    int exp_half = 2;
    int hp_err = 0, gap_err = 0, mode_err = 0;

    always #2.5 clk = ~clk;

    sram_spi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Memory model: frame start
    always @(negedge spi_cs_n) begin
        bitc = 0;
        cap  = '0;
    end
    // Memory model: capture output bits on rising clock
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cap  = {cap[62:0], spi_mosi};
            bitc = bitc + 1;
            if (bitc == 24) begin
                ins_l = cap[23:16];
                adr_l = cap[15:0];
            end
        end
    end
    // Memory model: drive input bits on falling clock during a read
    always @(negedge spi_sck) begin
        if (!spi_cs_n && bitc >= 24 && ins_l == 8'h03) begin
            spi_miso = mem[8'(adr_l + 16'((bitc - 24) / 8))][7 - ((bitc - 24) % 8)];
        end
    end
    // Memory model: frame end, decode and apply stores
    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            frames    = frames + 1;
            last_bits = bitc;
            last_cap  = cap;
            if (bitc == 56 && cap[55:48] == 8'h02) begin
                for (int i = 0; i < 4; i++)
                    mem[8'(cap[47:32] + 16'(i))] = cap[31 - 8*i -: 8];
            end
        end
    end

    // Timing monitor: half-periods, chip-select gaps, mode-0 output hold
    int since = 0, gap = 1000;
    logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    always @(negedge clk) begin
        since = since + 1;
        gap   = gap + 1;
        if (rst_n) begin
            if (p_cs && !spi_cs_n) begin
                if (gap < exp_half) gap_err = gap_err + 1;
                since = 0;
            end else if (!spi_cs_n && spi_sck != p_sck) begin
                if (since != exp_half) hp_err = hp_err + 1;
                since = 0;
            end
            if (!p_cs || !spi_cs_n) gap = (!p_cs && spi_cs_n) ? 0 : gap;
            if (!p_sck && spi_sck && spi_mosi != p_mosi) mode_err = mode_err + 1;
            if (spi_sck && spi_cs_n) mode_err = mode_err + 1;
        end
        p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        s = 32'h0;
        for (int i = 0; i < 5000 && s[0] == 1'b0; i++) bus_rd(8'h09, s);
    endtask

    task automatic set_div(input int d);
        bus_wr(8'h0A, 32'(d));
        exp_half = (d == 0) ? 1 : d;
    endtask

    initial begin
        #(5ns * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int f0;
        logic [15:0] adrs [3];
        logic [31:0] wrds [3];
        int divs [5];
        adrs = '{16'h0000, 16'h1234, 16'h00FE};
        wrds = '{32'hDEADBEEF, 32'h01234567, 32'hA5C3_0F81};
        divs = '{0, 1, 2, 3, 6};
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        bus_rd(8'h09, r); check(r == 32'h1, "R3 reset status", r, 32'h1);
        bus_rd(8'h0A, r); check(r == 32'h2, "R1 reset divider", r, 32'h2);
        check(spi_cs_n && !spi_sck, "R7 idle pins", {spi_cs_n, spi_sck}, 2'b10);

        // Register read-back sweep
        for (int v = 0; v < 256; v += 51) begin
            bus_wr(8'h0A, 32'(v)); bus_rd(8'h0A, r);
            check(r == 32'(v), "R1 divider readback", r, 32'(v));
        end
        bus_wr(8'h10, 32'hCAFE0042); bus_rd(8'h10, r);
        check(r == 32'hCAFE0042, "R1 address readback", r, 32'hCAFE0042);
        bus_rd(8'h08, r); check(r == 32'h0, "R1 command reads zero", r, 0);

        // Preparation
        set_div(1);
        bus_wr(8'h08, 32'h4);
        bus_rd(8'h09, r); check(r[0] == 1'b0, "R3 busy during prep", r, 0);
        wait_ready();
        bus_rd(8'h09, r); check(r == 32'h3, "R3 prep flag set", r, 32'h3);
        check(last_bits == 16, "R4 prep length", last_bits, 16);
        check(last_cap[15:0] == 16'h0140, "R4 prep bytes", last_cap[15:0], 16'h0140);

        // Store / fetch sweep over dividers and address/data patterns
        for (int di = 0; di < 5; di++) begin
            set_div(divs[di]);
            for (int k = 0; k < 3; k++) begin
                logic [31:0] w;
                logic [15:0] a;
                w = wrds[k] ^ 32'(di * 32'h01010101);
                a = adrs[k] + 16'(di);
                bus_wr(8'h10, {16'hBEEF, a});
                bus_wr(8'h20, w);
                bus_wr(8'h08, 32'h2);
                wait_ready();
                check(last_bits == 56, "R5 store length", last_bits, 56);
                check(last_cap[55:0] == {8'h02, a, w}, "R5 store frame", last_cap[55:0], {8'h02, a, w});
                bus_wr(8'h20, 32'h0);
                bus_wr(8'h08, 32'h1);
                wait_ready();
                check(last_bits == 56 && last_cap[55:32] == {8'h03, a},
                      "R6 fetch header", last_cap[55:32], {8'h03, a});
                bus_rd(8'h20, r); check(r == w, "R6 round trip", r, w);
            end
            check(hp_err == 0, "R8 half-period", hp_err, 0);
        end
        bus_rd(8'h09, r); check(r == 32'h3, "R3 prep flag sticky", r, 32'h3);

        // Fetch of a location never stored: expected from the fill formula
        bus_wr(8'h10, 32'h0080);
        bus_wr(8'h08, 32'h1);
        wait_ready();
        bus_rd(8'h20, r);
        check(r == {8'(128*7+3), 8'(129*7+3), 8'(130*7+3), 8'(131*7+3)},
              "R6 preset fetch", r, {8'(128*7+3), 8'(129*7+3), 8'(130*7+3), 8'(131*7+3)});

        // Commands while busy are ignored
        set_div(6);
        bus_wr(8'h10, 32'h0040);
        bus_wr(8'h20, 32'h13579BDF);
        f0 = frames;
        bus_wr(8'h08, 32'h2);
        repeat (40) @(negedge clk);
        bus_wr(8'h08, 32'h1);
        bus_wr(8'h08, 32'h4);
        wait_ready();
        repeat (20) @(negedge clk);
        check(frames == f0 + 1, "R9 single frame", frames, f0 + 1);
        bus_rd(8'h20, r); check(r == 32'h13579BDF, "R9 data kept", r, 32'h13579BDF);

        // Invalid command codes
        f0 = frames;
        bus_wr(8'h08, 32'h3); bus_wr(8'h08, 32'h0); bus_wr(8'h08, 32'h8);
        bus_wr(8'h08, 32'h104);
        bus_rd(8'h09, r); check(r[0] == 1'b1, "R2 no start on bad code", r, 1);
        repeat (30) @(negedge clk);
        check(frames == f0, "R2 no frame on bad code", frames, f0);

        // Back-to-back commands for chip-select gap
        set_div(3);
        bus_wr(8'h08, 32'h2); wait_ready();
        bus_wr(8'h08, 32'h1); wait_ready();
        check(gap_err == 0, "R10 chip-select gap", gap_err, 0);
        check(mode_err == 0, "R7 mode-0 behaviour", mode_err, 0);
        check(hp_err == 0, "R8 half-period final", hp_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule